// File: doc/BRIEF.md
# Dual-Half Capture Timer/Counter

This block is a 16-bit timer/counter that can also run as two 8-bit halves. A 2-bit mode field sets how the halves are clocked and whether they are chained. Each half counts either ticks from its own programmable prescaler or rising edges of an external event input. Each half compares its count with a programmed period. On a match the half reloads to zero and pulses its interrupt output. In the 16-bit modes the halves form one counter, with the low half carrying into the high half.

Software programs the block through a small register port. A write selects a register by address, and a separate read address returns any register combinationally. The external event input and the two capture strobes are asynchronous to the clock. A rising edge on a capture strobe latches the current count into the capture register. The capture width follows the mode: each strobe latches its own half in the 8-bit modes, and either strobe latches all 16 bits in the 16-bit modes.

Top module: `dual_cap_timer`

## Requirements
- R1: After reset, every readable register (control, prescale, period, count and capture) reads zero, and both interrupt outputs are low.
- R2: A write at address 0 sets the control register: mode in bits [1:0], low-half run in bit 2, high-half run in bit 3. Address 1 holds the prescale limits, with the low half in [7:0] and the high half in [15:8]. Address 2 holds the periods in the same layout. On the read port, addresses 0, 1 and 2 return these registers, address 3 returns the count {high, low} and address 4 returns the capture {high, low}.
- R3: In mode 0, each half is a timer on its own prescaler, which ticks once every (prescale+1) cycles. Each half's interrupt therefore repeats every (prescale+1)*(period+1) cycles, and the two halves are independent of each other.
- R4: An interrupt is a single-cycle pulse. It is high in exactly the cycle in which the matching count reads zero after its reload.
- R5: In mode 1, the low half is a prescaled timer and the high half counts event edges. The high half wraps to zero and pulses its interrupt on the edge that arrives when its count equals its period.
- R6: In mode 2, both halves form one 16-bit timer on the low prescaler, with the 16-bit period {high, low}. The interrupt repeats every (prescale_low+1)*(period+1) cycles on the high output only, and the low output stays low.
- R7: In mode 3, the block is a 16-bit event counter with no prescaler. The low half carries into the high half at 0xFF, and when the count equals the 16-bit period the counter reloads to zero and pulses the high interrupt.
- R8: The event input passes through a two-stage synchronizer, and each rising edge is counted once. A count taken on an event edge becomes visible on the third clock edge after the input rises.
- R9: In modes 0 and 1, a rising edge on the low capture strobe latches only the low count into the low capture byte. A rising edge on the high capture strobe latches only the high count into the high capture byte.
- R10: In modes 2 and 3, a rising edge on either capture strobe latches all 16 count bits at once.
- R11: While both run bits are clear and no control write occurs, the count holds its value.
- R12: A control write while either run bit is set updates only the run bits and leaves the mode unchanged. A control write while both run bits are clear loads the mode and clears both counts and both prescalers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 prescale, 2 period |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address: 0 to 4 as in R2 |
| rd_data_o | output | 16 | Read data, combinational |
| evt_i | input | 1 | External event input, asynchronous |
| cap_lo_i | input | 1 | Low-half capture strobe, asynchronous |
| cap_hi_i | input | 1 | High-half capture strobe, asynchronous |
| irq_lo_o | output | 1 | Low-half match pulse |
| irq_hi_o | output | 1 | High-half or 16-bit match pulse |

## Verification
The assertions check the following on every cycle:
- each interrupt pulse coincides with a zero count;
- the low interrupt stays silent in the 16-bit modes;
- the mode is frozen while any run bit is set;
- a stopped counter holds its value;
- the capture register changes only on a strobe edge.

Only the bench's scenarios can show the arithmetic:
- the (prescale+1)*(period+1) repeat intervals swept across several settings;
- the carry from the low half into the high half;
- the exact three-edge latency of an event;
- which capture byte each strobe loads in each mode.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'd0,
    MODE_T8_E8 = 2'd1,
    MODE_T16   = 2'd2,
    MODE_E16   = 2'd3
  } dct_mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PRESC  = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  localparam logic [2:0] RADDR_CTRL   = 3'd0;
  localparam logic [2:0] RADDR_PRESC  = 3'd1;
  localparam logic [2:0] RADDR_PERIOD = 3'd2;
  localparam logic [2:0] RADDR_COUNT  = 3'd3;
  localparam logic [2:0] RADDR_CAPT   = 3'd4;
endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '0;
      last_q <= '0;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dct_half.sv
module dct_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         zero_i,
  input  logic         inc_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         at_period_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (zero_i)  cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign at_period_o = (cnt_q == period_i);
  assign at_max_o    = &cnt_q;
endmodule

// File: rtl/dual_cap_timer.sv
module dual_cap_timer
  import dct_pkg::*;
#(
  parameter  int unsigned HALF_W      = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned FULL_W      = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [FULL_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [FULL_W-1:0] rd_data_o,
  input  logic              evt_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  dct_mode_e         mode_q;
  logic              run_lo_q, run_hi_q;
  logic [HALF_W-1:0] pre_lo_q, pre_hi_q, per_lo_q, per_hi_q;
  logic [HALF_W-1:0] capt_lo_q, capt_hi_q;
  logic              irq_lo_q, irq_hi_q;

  logic ctrl_wr, stopped, clr, is16;
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign stopped = !run_lo_q && !run_hi_q;
  assign clr     = ctrl_wr && stopped;
  assign is16    = (mode_q == MODE_T16) || (mode_q == MODE_E16);

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DUAL8;
      run_lo_q <= 1'b0;
      run_hi_q <= 1'b0;
      pre_lo_q <= '0;
      pre_hi_q <= '0;
      per_lo_q <= '0;
      per_hi_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTRL: begin
          run_lo_q <= wr_data_i[2];
          run_hi_q <= wr_data_i[3];
          if (stopped) mode_q <= dct_mode_e'(wr_data_i[1:0]);
        end
        ADDR_PRESC: begin
          pre_lo_q <= wr_data_i[HALF_W-1:0];
          pre_hi_q <= wr_data_i[FULL_W-1:HALF_W];
        end
        ADDR_PERIOD: begin
          per_lo_q <= wr_data_i[HALF_W-1:0];
          per_hi_q <= wr_data_i[FULL_W-1:HALF_W];
        end
        default: ;
      endcase
    end
  end

  // synchronised edges: [0] event, [1] low capture, [2] high capture
  logic [2:0] rise;
  dct_edge_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cap_hi_i, cap_lo_i, evt_i}),
    .rise_o (rise)
  );

  logic pre_lo_tick, pre_hi_tick;
  dct_prescaler #(.W(HALF_W)) u_pre_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run_lo_q && (mode_q != MODE_E16)),
    .clr_i   (clr),
    .limit_i (pre_lo_q),
    .tick_o  (pre_lo_tick)
  );
  dct_prescaler #(.W(HALF_W)) u_pre_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run_hi_q && (mode_q == MODE_DUAL8)),
    .clr_i   (clr),
    .limit_i (pre_hi_q),
    .tick_o  (pre_hi_tick)
  );

  logic tick_lo8, tick_hi8, tick16;
  assign tick_lo8 = pre_lo_tick;
  assign tick_hi8 = (mode_q == MODE_DUAL8) ? pre_hi_tick : (run_hi_q && rise[0]);
  assign tick16   = run_lo_q && ((mode_q == MODE_T16) ? pre_lo_tick : rise[0]);

  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic lo_at_per, hi_at_per, lo_at_max, hi_at_max;
  logic lo_inc, lo_zero, hi_inc, hi_zero, irq_lo_d, irq_hi_d, match16;
  assign match16 = lo_at_per && hi_at_per;

  always_comb begin
    if (is16) begin
      lo_inc   = tick16 && !match16;
      lo_zero  = clr || (tick16 && match16);
      hi_inc   = lo_inc && lo_at_max;
      hi_zero  = lo_zero;
      irq_lo_d = 1'b0;
      irq_hi_d = tick16 && match16;
    end else begin
      lo_inc   = tick_lo8 && !lo_at_per;
      lo_zero  = clr || (tick_lo8 && lo_at_per);
      hi_inc   = tick_hi8 && !hi_at_per;
      hi_zero  = clr || (tick_hi8 && hi_at_per);
      irq_lo_d = tick_lo8 && lo_at_per;
      irq_hi_d = tick_hi8 && hi_at_per;
    end
  end

  dct_half #(.W(HALF_W)) u_half_lo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zero_i      (lo_zero),
    .inc_i       (lo_inc),
    .period_i    (per_lo_q),
    .cnt_o       (cnt_lo),
    .at_period_o (lo_at_per),
    .at_max_o    (lo_at_max)
  );
  dct_half #(.W(HALF_W)) u_half_hi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zero_i      (hi_zero),
    .inc_i       (hi_inc),
    .period_i    (per_hi_q),
    .cnt_o       (cnt_hi),
    .at_period_o (hi_at_per),
    .at_max_o    (hi_at_max)
  );

  // capture and interrupt registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capt_lo_q <= '0;
      capt_hi_q <= '0;
      irq_lo_q  <= 1'b0;
      irq_hi_q  <= 1'b0;
    end else begin
      irq_lo_q <= irq_lo_d;
      irq_hi_q <= irq_hi_d;
      if (is16) begin
        if (rise[1] || rise[2]) begin
          capt_lo_q <= cnt_lo;
          capt_hi_q <= cnt_hi;
        end
      end else begin
        if (rise[1]) capt_lo_q <= cnt_lo;
        if (rise[2]) capt_hi_q <= cnt_hi;
      end
    end
  end

  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;

  always_comb begin
    unique case (rd_addr_i)
      RADDR_CTRL:   rd_data_o = {{(FULL_W-4){1'b0}}, run_hi_q, run_lo_q, mode_q};
      RADDR_PRESC:  rd_data_o = {pre_hi_q, pre_lo_q};
      RADDR_PERIOD: rd_data_o = {per_hi_q, per_lo_q};
      RADDR_COUNT:  rd_data_o = {cnt_hi, cnt_lo};
      RADDR_CAPT:   rd_data_o = {capt_hi_q, capt_lo_q};
      default:      rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned HALF_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          mode_i,
  input logic                run_lo_i,
  input logic                run_hi_i,
  input logic                ctrl_wr_i,
  input logic [HALF_W-1:0]   cnt_lo_i,
  input logic [HALF_W-1:0]   cnt_hi_i,
  input logic [2*HALF_W-1:0] capt_i,
  input logic [1:0]          cap_rise_i,
  input logic                irq_lo_i,
  input logic                irq_hi_i
);
  AST_IRQ_LO_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_i |-> (cnt_lo_i == '0)); // R4

  AST_IRQ_HI_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_i |-> (cnt_hi_i == '0)); // R4

  AST_WIDE_LO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> !irq_lo_i); // R6

  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_lo_i || run_hi_i) |=> $stable(mode_i)); // R12

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_lo_i && !run_hi_i && !ctrl_wr_i) |=> $stable({cnt_hi_i, cnt_lo_i})); // R11

  AST_CAPT_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rise_i == 2'b00) |=> $stable(capt_i)); // R9
endmodule

bind dual_cap_timer dct_checker #(.HALF_W(HALF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_q),
  .run_lo_i   (run_lo_q),
  .run_hi_i   (run_hi_q),
  .ctrl_wr_i  (ctrl_wr),
  .cnt_lo_i   (cnt_lo),
  .cnt_hi_i   (cnt_hi),
  .capt_i     ({capt_hi_q, capt_lo_q}),
  .cap_rise_i (rise[2:1]),
  .irq_lo_i   (irq_lo_o),
  .irq_hi_i   (irq_hi_o)
);

// File: tb/dual_cap_timer_bench.sv
module dual_cap_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        evt_i = 1'b0, cap_lo_i = 1'b0, cap_hi_i = 1'b0;
  logic        irq_lo_o, irq_hi_o;

  int n_vec = 0, n_bad = 0;
  int n_irq_lo = 0, n_irq_hi = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dual_cap_timer u_dual_cap_timer (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .evt_i, .cap_lo_i, .cap_hi_i, .irq_lo_o, .irq_hi_o
  );

  always @(negedge clk_i) begin
    if (irq_lo_o) n_irq_lo++;
    if (irq_hi_o) n_irq_hi++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic evt_pulse();
    @(negedge clk_i); evt_i = 1'b1;
    idle(2);          evt_i = 1'b0;
    idle(2);
  endtask

  task automatic evt_burst(input int n);
    for (int i = 0; i < n; i++) evt_pulse();
    idle(3);
  endtask

  task automatic cap_pulse(input bit hi);
    @(negedge clk_i);
    if (hi) cap_hi_i = 1'b1; else cap_lo_i = 1'b1;
    idle(2);
    cap_hi_i = 1'b0; cap_lo_i = 1'b0;
    idle(4);
  endtask

  task automatic irq_gap(input bit hi, output int gap);
    int t;
    gap = -1;
    t = 0;
    while (!(hi ? irq_hi_o : irq_lo_o) && t < 4000) begin @(negedge clk_i); t++; end
    if (t >= 4000) return;
    t = 0;
    do begin @(negedge clk_i); t++; end while (!(hi ? irq_hi_o : irq_lo_o) && t < 4000);
    if (t < 4000) gap = t;
  endtask

  initial begin
    #(4 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    logic [15:0] v, c;
    int g, base_lo, base_hi;

    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 irq_lo", irq_lo_o, 0);
    chk("R1 irq_hi", irq_hi_o, 0);

    // R2 register layout
    wr(2'd1, 16'h1234); rd(3'd1, v); chk("R2 prescale", v, 16'h1234);
    wr(2'd2, 16'hA5C3); rd(3'd2, v); chk("R2 period", v, 16'hA5C3);
    wr(2'd0, 16'h0009); rd(3'd0, v); chk("R2 control", v, 16'h0009);
    wr(2'd0, 16'h0000);

    // R3 mode 0 sweep of prescale and period
    for (int pl = 0; pl < 3; pl += 2) begin
      for (int pr = 1; pr < 5; pr += 3) begin
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'((pl + 1) << 8 | pl));
        wr(2'd2, 16'((pr + 1) << 8 | pr));
        wr(2'd0, 16'h000C);
        irq_gap(1'b0, g);
        chk($sformatf("R3 lo gap pl=%0d pr=%0d", pl, pr), g, (pl + 1) * (pr + 1));
        irq_gap(1'b1, g);
        chk($sformatf("R3 hi gap pl=%0d pr=%0d", pl, pr), g, (pl + 2) * (pr + 2));
      end
    end

    // R4 pulse coincides with zero count and lasts one cycle
    while (!irq_lo_o) @(negedge clk_i);
    rd(3'd3, v);
    chk("R4 lo count at pulse", v[7:0], 0);
    @(negedge clk_i);
    chk("R4 pulse width", irq_lo_o, 0);

    // R12 mode locked while running; stopped write clears
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h000C);
    idle(10);
    wr(2'd0, 16'h000E);
    rd(3'd0, v); chk("R12 mode kept while running", v, 16'h000C);
    wr(2'd0, 16'h0002);
    rd(3'd0, v); chk("R12 stop keeps mode", v, 16'h0000);
    rd(3'd3, c);
    chk("R11 count nonzero before hold", (c != 0), 1);
    idle(20);
    rd(3'd3, v); chk("R11 count holds while stopped", v, c);
    wr(2'd0, 16'h0000);
    rd(3'd3, v); chk("R12 stopped write clears count", v, 0);

    // R6 mode 2 chained 16-bit timer
    wr(2'd2, 16'h0103);
    wr(2'd0, 16'h0006);
    base_lo = n_irq_lo;
    irq_gap(1'b1, g);
    chk("R6 16-bit gap prescale 0", g, 260);
    chk("R6 low irq silent", n_irq_lo - base_lo, 0);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0006);
    irq_gap(1'b1, g);
    chk("R6 16-bit gap prescale 1", g, 520);
    wr(2'd0, 16'h0000);

    // R5 / R8 mode 1: low timer, high event counter
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0302);
    wr(2'd0, 16'h000D);
    irq_gap(1'b0, g);
    chk("R5 low timer gap", g, 6);
    base_hi = n_irq_hi;
    @(negedge clk_i); evt_i = 1'b1;
    @(negedge clk_i); rd(3'd3, v); chk("R8 no count after 1 edge", v[15:8], 0);
    @(negedge clk_i); rd(3'd3, v); chk("R8 no count after 2 edges", v[15:8], 0);
    @(negedge clk_i); rd(3'd3, v); chk("R8 counted after 3 edges", v[15:8], 1);
    evt_i = 1'b0;
    idle(3);
    evt_burst(3);
    rd(3'd3, v);
    chk("R5 high wrapped at period", v[15:8], 0);
    chk("R5 high irq count", n_irq_hi - base_hi, 1);
    evt_burst(2);
    rd(3'd3, v);
    chk("R5 high counts one per edge", v[15:8], 2);

    // R7 mode 3 16-bit event counter with carry
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0102);
    wr(2'd0, 16'h0007);
    base_lo = n_irq_lo; base_hi = n_irq_hi;
    evt_burst(255); rd(3'd3, v); chk("R7 count 0xFF", v, 16'h00FF);
    evt_burst(1);   rd(3'd3, v); chk("R7 carry into high", v, 16'h0100);
    evt_burst(2);   rd(3'd3, v); chk("R7 count at period", v, 16'h0102);
    chk("R7 no irq before match", n_irq_hi - base_hi, 0);
    evt_burst(1);   rd(3'd3, v); chk("R7 reload to zero", v, 0);
    chk("R7 high irq once", n_irq_hi - base_hi, 1);
    chk("R7 low irq silent", n_irq_lo - base_lo, 0);

    // R10 16-bit capture from either strobe
    evt_burst(257);
    rd(3'd3, v); chk("R7 count 0x0101", v, 16'h0101);
    wr(2'd0, 16'h0000);
    cap_pulse(1'b1);
    rd(3'd4, v); chk("R10 high strobe latches 16 bits", v, 16'h0101);

    // R9 8-bit captures are per half
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h000C);
    idle(20);
    wr(2'd0, 16'h0000);
    rd(3'd3, c);
    cap_pulse(1'b0);
    rd(3'd4, v); chk("R9 low strobe latches low byte only", v, {8'h01, c[7:0]});
    cap_pulse(1'b1);
    rd(3'd4, v); chk("R9 high strobe latches high byte", v, c);
    chk("R9 halves differ", (c[15:8] != c[7:0]), 1);

    done = 1'b1;
    report();
  end
endmodule